// File: doc/BRIEF.md
# One-Time-Programmable Word Programming Sequencer

This block controls a device programmer that burns a 16-bit image into a one-time-programmable memory of up to 32K words. It fetches each source word from a synchronous image memory and drives the target's address and data lines. It also drives an active-low program strobe, active-low chip and output enables, and two supply-select outputs. One selects the programming level of the core supply and the other the programming level of the high-voltage programming supply.

A run starts from idle. The core supply is raised first and the programming supply after it, with a settling wait after each change. In the first pass every word gets a single strobe pulse and is not read back. In the second pass each word is read and compared; a word that fails gets further pulses, each followed by a read, up to a retry limit. Both supplies then return to nominal and a final full read-back decides the result. Image words that are all ones are skipped throughout, since an unprogrammed cell already reads as one. On failure, the address and the retry count reached are kept, and the supplies are brought back to nominal before `done` is raised. An abort input ends a run at any point.

Top module: `otp_prog_seq`

## Requirements
- R1: After reset the strobe, chip enable and output enable are high (inactive), both supply selects are 0, and `busy` and `done` are 0. `start` is taken only while idle; a `start` during a run has no effect on the run.
- R2: The core-supply select rises exactly SETTLE_CYC cycles before the programming-supply select. On the way down the programming-supply select falls exactly SETTLE_CYC cycles before the core-supply select. The programming supply is never selected while the core supply is not.
- R3: Every completed strobe pulse (`pgm_n` low) lasts exactly PULSE_CYC cycles. During a pulse both supply selects are 1, `ce_n` is 0 and `oe_n` is 1.
- R4: The first pass applies exactly one pulse to each word that is not all ones, and makes no verify read before the first pass ends.
- R5: In the second pass, a word that needs k pulses in total (k ≤ MAX_RETRY+1) receives exactly k pulses, and the run passes.
- R6: If a word still reads wrong after MAX_RETRY retry pulses, the run ends with `pass`=0, `fail_addr` equal to that word and `fail_retries` equal to MAX_RETRY. That word has then received MAX_RETRY+1 pulses, no later word gets a second-pass pulse, and both supply selects are 0 when `done` is 1.
- R7: An image word equal to all ones (16'hFFFF) receives no pulse.
- R8: For a verify read, `ce_n` is already 0 in the cycle before `oe_n` falls. `oe_n` then stays low for exactly ACCESS_CYC cycles with `pgm_n` high.
- R9: After both supplies are back at nominal, every non-all-ones word is read again. A mismatch gives `pass`=0 with `fail_addr` at that word and `fail_retries`=0; no mismatch gives `pass`=1. `done` is a one-cycle pulse.
- R10: When `abort` is high during a run, `pgm_n` is high from the next cycle. The supplies are then lowered in order, and the run ends with `done` and `pass`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a programming run (idle only) |
| abort | input | 1 | Abandon the current run |
| img_addr | output | ADDR_W | Image memory read address |
| img_data | input | DATA_W | Image memory read data, one cycle after the address |
| dev_addr | output | ADDR_W | Target word address |
| dev_wdata | output | DATA_W | Word to be programmed |
| dev_rdata | input | DATA_W | Word read back from the target |
| pgm_n | output | 1 | Program strobe, active low |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| vcc_prog | output | 1 | Core supply at programming level |
| vpp_prog | output | 1 | Programming supply at high level |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| pass | output | 1 | Result of the last run |
| fail_addr | output | ADDR_W | Address that failed or was active at abort |
| fail_retries | output | RTY_W | Retry pulses reached on the failing word |

## Verification
The abort input can arrive in the same cycle as an active programming pulse. The sequencer must then stop the strobe, skip any further programming, and start the supply ramp-down. The bench waits until it sees `pgm_n` low, raises `abort` for one cycle, and expects `pgm_n` high on the next falling edge. It then expects the run to finish with `pass`=0 and both supplies back at nominal. A second overlap is a `start` raised while a run is under way; this is judged by the exact per-word pulse counts of that run, which a restart would inflate.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_VCC_UP, S_VPP_UP, S_FETCH, S_DECIDE, S_PULSE,
    S_RD_CE, S_RD_OE, S_RD_END, S_CHECK, S_NEXT,
    S_VPP_DN, S_VCC_DN, S_FINISH
  } seq_state_t;

  typedef enum logic [1:0] {
    PH_BLIND, PH_VERIFY, PH_READBACK
  } phase_t;

endpackage

// File: rtl/otp_delay_timer.sv
module otp_delay_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/otp_retry_ctr.sv
module otp_retry_ctr #(
  parameter int MAX_RETRY = 10,
  localparam int RTY_W = $clog2(MAX_RETRY + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             inc,
  output logic [RTY_W-1:0] count,
  output logic             full
);
  always_ff @(posedge clk) begin
    if (rst || clr)           count <= '0;
    else if (inc && !full)    count <= count + 1'b1;
  end

  assign full = (count == RTY_W'(MAX_RETRY));

  AST_RETRY_BOUND: assert property (@(posedge clk) disable iff (rst)
    count <= RTY_W'(MAX_RETRY)); // R5
endmodule

// File: rtl/otp_verify_cmp.sv
module otp_verify_cmp #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] exp_data,
  output logic              match
);
  always_ff @(posedge clk) begin
    if (rst)         match <= 1'b0;
    else if (sample) match <= (rd_data == exp_data);
  end
endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_prog_pkg::*;
#(
  parameter int NUM_WORDS  = 32768,
  parameter int DATA_W     = 16,
  parameter int PULSE_CYC  = 6250,
  parameter int SETTLE_CYC = 1250,
  parameter int ACCESS_CYC = 8,
  parameter int MAX_RETRY  = 10,
  localparam int ADDR_W = $clog2(NUM_WORDS),
  localparam int RTY_W  = $clog2(MAX_RETRY + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              abort,
  output logic [ADDR_W-1:0] img_addr,
  input  logic [DATA_W-1:0] img_data,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [DATA_W-1:0] dev_wdata,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic              pgm_n,
  output logic              ce_n,
  output logic              oe_n,
  output logic              vcc_prog,
  output logic              vpp_prog,
  output logic              busy,
  output logic              done,
  output logic              pass,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [RTY_W-1:0]  fail_retries
);
  localparam int MAX_A   = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
  localparam int MAX_DLY = (MAX_A > ACCESS_CYC) ? MAX_A : ACCESS_CYC;
  localparam int CNT_W   = $clog2(MAX_DLY + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(NUM_WORDS - 1);

  seq_state_t        state, state_d;
  phase_t            phase;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] word;
  logic              failing;
  logic              tmr_load, tmr_zero;
  logic [CNT_W-1:0]  tmr_val;
  logic              sample, match, abort_take, check_fail;
  logic              rty_clr, rty_inc, rty_full;
  logic [RTY_W-1:0]  rty_cnt;

  otp_delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero));

  otp_retry_ctr #(.MAX_RETRY(MAX_RETRY)) u_retry (
    .clk(clk), .rst(rst), .clr(rty_clr), .inc(rty_inc),
    .count(rty_cnt), .full(rty_full));

  otp_verify_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .sample(sample), .rd_data(dev_rdata),
    .exp_data(word), .match(match));

  // next-state logic
  always_comb begin
    state_d    = state;
    sample     = 1'b0;
    abort_take = 1'b0;
    unique case (state)
      S_IDLE:   if (start) state_d = S_VCC_UP;
      S_VCC_UP: if (tmr_zero) state_d = S_VPP_UP;
      S_VPP_UP: if (tmr_zero) state_d = S_FETCH;
      S_FETCH:  state_d = S_DECIDE;
      S_DECIDE: begin
        if (img_data == '1)          state_d = S_NEXT;
        else if (phase == PH_BLIND)  state_d = S_PULSE;
        else                         state_d = S_RD_CE;
      end
      S_PULSE:  if (tmr_zero) state_d = (phase == PH_BLIND) ? S_NEXT : S_RD_CE;
      S_RD_CE:  state_d = S_RD_OE;
      S_RD_OE:  if (tmr_zero) begin sample = 1'b1; state_d = S_RD_END; end
      S_RD_END: state_d = S_CHECK;
      S_CHECK: begin
        if (match)                                  state_d = S_NEXT;
        else if (phase == PH_VERIFY && !rty_full)   state_d = S_PULSE;
        else                                        state_d = S_VPP_DN;
      end
      S_NEXT: begin
        if (addr != LAST_ADDR)            state_d = S_FETCH;
        else if (phase == PH_BLIND)       state_d = S_FETCH;
        else if (phase == PH_VERIFY)      state_d = S_VPP_DN;
        else                              state_d = S_FINISH;
      end
      S_VPP_DN: if (tmr_zero) state_d = S_VCC_DN;
      S_VCC_DN: if (tmr_zero)
        state_d = (failing || abort || phase != PH_VERIFY) ? S_FINISH : S_FETCH;
      S_FINISH: state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
    if (abort && !(state inside {S_IDLE, S_VPP_DN, S_VCC_DN, S_FINISH})) begin
      state_d    = S_VPP_DN;
      abort_take = 1'b1;
      sample     = 1'b0;
    end
  end

  assign check_fail = (state == S_CHECK) && (state_d == S_VPP_DN) && !abort_take;

  // one timer serves every timed state; it is reloaded on each state change
  assign tmr_load = (state_d != state);
  always_comb begin
    unique case (state_d)
      S_PULSE:                                 tmr_val = CNT_W'(PULSE_CYC - 1);
      S_RD_OE:                                 tmr_val = CNT_W'(ACCESS_CYC - 1);
      S_VCC_UP, S_VPP_UP, S_VPP_DN, S_VCC_DN:  tmr_val = CNT_W'(SETTLE_CYC - 1);
      default:                                 tmr_val = '0;
    endcase
  end

  assign rty_clr = (state_d == S_FETCH) || (state == S_IDLE);
  assign rty_inc = (state == S_PULSE) && tmr_zero && (phase == PH_VERIFY) && !abort_take;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; phase <= PH_BLIND; addr <= '0; word <= '0;
      failing <= 1'b0; pass <= 1'b0; fail_addr <= '0; fail_retries <= '0;
    end else begin
      state <= state_d;
      if (state == S_IDLE && start) begin
        phase <= PH_BLIND; addr <= '0; failing <= 1'b0; pass <= 1'b0;
        fail_addr <= '0; fail_retries <= '0;
      end
      if (state == S_DECIDE) word <= img_data;
      if (state == S_NEXT && !abort_take) begin
        if (addr != LAST_ADDR) addr <= addr + 1'b1;
        else begin
          addr <= '0;
          if (phase == PH_BLIND) phase <= PH_VERIFY;
        end
      end
      if (state == S_VCC_DN && state_d == S_FETCH) phase <= PH_READBACK;
      if (abort_take || check_fail) begin
        failing <= 1'b1; fail_addr <= addr; fail_retries <= rty_cnt;
      end
      if (abort && (state inside {S_VPP_DN, S_VCC_DN})) failing <= 1'b1;
      if (state_d == S_FINISH) pass <= !(failing || abort);
    end
  end

  // registered pin outputs, decoded from the next state
  always_ff @(posedge clk) begin
    if (rst) begin
      pgm_n <= 1'b1; ce_n <= 1'b1; oe_n <= 1'b1;
      vcc_prog <= 1'b0; vpp_prog <= 1'b0; busy <= 1'b0; done <= 1'b0;
    end else begin
      pgm_n <= (state_d != S_PULSE);
      ce_n  <= !(state_d inside {S_PULSE, S_RD_CE, S_RD_OE, S_RD_END});
      oe_n  <= (state_d != S_RD_OE);
      if (state_d == S_VCC_UP)      vcc_prog <= 1'b1;
      else if (state_d == S_VCC_DN) vcc_prog <= 1'b0;
      if (state_d == S_VPP_UP)      vpp_prog <= 1'b1;
      else if (state_d == S_VPP_DN) vpp_prog <= 1'b0;
      busy <= (state_d != S_IDLE);
      done <= (state_d == S_FINISH);
    end
  end

  assign img_addr  = addr;
  assign dev_addr  = addr;
  assign dev_wdata = word;

  AST_VPP_NEEDS_VCC: assert property (@(posedge clk) disable iff (rst)
    vpp_prog |-> vcc_prog); // R2
  AST_PULSE_CONDITIONS: assert property (@(posedge clk) disable iff (rst)
    !pgm_n |-> (vcc_prog && vpp_prog && !ce_n && oe_n)); // R3
  AST_OE_AFTER_CE: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n) |-> ($past(!ce_n) && pgm_n)); // R8
  AST_ABORT_STROBE: assert property (@(posedge clk) disable iff (rst)
    abort |=> pgm_n); // R10
  AST_DONE_NOMINAL: assert property (@(posedge clk) disable iff (rst)
    done |-> (!vcc_prog && !vpp_prog)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
endmodule

// File: tb/tb_otp_prog_seq.sv
module tb_otp_prog_seq;
  localparam int NW = 8, DW = 16, PW = 5, SW = 4, AW_C = 3, MR = 10;
  localparam int AW = 3, RW = 4;

  logic clk = 0, rst = 1, start = 0, abort = 0;
  logic [AW-1:0] img_addr, dev_addr, fail_addr;
  logic [DW-1:0] img_data, dev_wdata, dev_rdata;
  logic pgm_n, ce_n, oe_n, vcc_prog, vpp_prog, busy, done, pass;
  logic [RW-1:0] fail_retries;

  always #4 clk = ~clk; // 125 MHz

  otp_prog_seq #(.NUM_WORDS(NW), .DATA_W(DW), .PULSE_CYC(PW), .SETTLE_CYC(SW),
                 .ACCESS_CYC(AW_C), .MAX_RETRY(MR)) dut (
    .clk(clk), .rst(rst), .start(start), .abort(abort),
    .img_addr(img_addr), .img_data(img_data), .dev_addr(dev_addr),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .pgm_n(pgm_n), .ce_n(ce_n),
    .oe_n(oe_n), .vcc_prog(vcc_prog), .vpp_prog(vpp_prog), .busy(busy),
    .done(done), .pass(pass), .fail_addr(fail_addr), .fail_retries(fail_retries));

  // image memory and target model
  logic [DW-1:0] img [NW];
  logic [DW-1:0] devmem [NW];
  int need [NW];
  int pcnt [NW];
  int weak_addr = -1;
  logic [DW-1:0] rd_word;

  always @(posedge clk) img_data <= img[img_addr];

  always_comb begin
    rd_word = devmem[dev_addr];
    if (!vcc_prog && int'(dev_addr) == weak_addr) rd_word = rd_word ^ 16'h0001;
    dev_rdata = (!ce_n && !oe_n) ? rd_word : '1;
  end

  // monitor
  int total = 0, bad = 0, cyc = 0;
  int pulse_len = 0, pulse_bad = 0, oe_len = 0, oe_bad = 0;
  int pulses_before_oe = 0, up_gap = -1, dn_gap = -1, vcc_r = 0, vpp_f = 0;
  bit oe_seen = 0, abort_test = 0;
  logic prev_pgm = 1, prev_oe = 1, prev_ce = 1, prev_vcc = 0, prev_vpp = 0;
  int pa; logic [DW-1:0] pwd;

  always @(posedge clk) begin
    cyc++;
    if (!pgm_n && prev_pgm) begin
      pa = int'(dev_addr); pwd = dev_wdata;
      if (!oe_seen) pulses_before_oe++;
    end
    if (!pgm_n) pulse_len++;
    if (pgm_n && !prev_pgm) begin
      if (!abort_test && pulse_len != PW) pulse_bad++;
      pcnt[pa]++;
      if (!abort_test && pcnt[pa] >= need[pa]) devmem[pa] = pwd;
      pulse_len = 0;
    end
    if (!oe_n) begin
      if (prev_oe && prev_ce) oe_bad++;
      oe_seen = 1; oe_len++;
    end
    if (oe_n && !prev_oe) begin
      if (oe_len != AW_C) oe_bad++;
      oe_len = 0;
    end
    if (vcc_prog && !prev_vcc) vcc_r = cyc;
    if (vpp_prog && !prev_vpp) up_gap = cyc - vcc_r;
    if (!vpp_prog && prev_vpp) vpp_f = cyc;
    if (!vcc_prog && prev_vcc) dn_gap = cyc - vpp_f;
    prev_pgm = pgm_n; prev_oe = oe_n; prev_ce = ce_n;
    prev_vcc = vcc_prog; prev_vpp = vpp_prog;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic prep(input logic [DW-1:0] im [NW]);
    for (int i = 0; i < NW; i++) begin
      img[i] = im[i]; devmem[i] = '1; need[i] = 1; pcnt[i] = 0;
    end
    weak_addr = -1; oe_seen = 0; pulses_before_oe = 0; pulse_bad = 0;
    oe_bad = 0; up_gap = -1; dn_gap = -1; abort_test = 0;
  endtask

  task automatic kick();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic wait_done(output bit ok);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    ok = done;
    if (!ok) chk(0, "watchdog", n, 0);
  endtask

  function automatic int nonff(input logic [DW-1:0] im [NW]);
    int c = 0;
    for (int i = 0; i < NW; i++) if (im[i] != '1) c++;
    return c;
  endfunction

  logic [DW-1:0] im1 [NW] = '{16'h1234, 16'hFFFF, 16'h0000, 16'hA5A5,
                             16'hFFFF, 16'h7FFE, 16'h0F0F, 16'h8001};

  task automatic t_reset();
    chk(pgm_n && ce_n && oe_n, "R1 reset strobes", {pgm_n, ce_n, oe_n}, 7);
    chk(!vcc_prog && !vpp_prog, "R1 reset supplies", {vcc_prog, vpp_prog}, 0);
    chk(!busy && !done, "R1 reset busy/done", {busy, done}, 0);
  endtask

  task automatic t_normal();
    bit ok;
    prep(im1);
    kick();
    repeat (40) @(negedge clk);
    start = 1; @(negedge clk) start = 0;   // R1: start while busy
    wait_done(ok);
    chk(pass == 1, "R9 normal run pass", pass, 1);
    for (int i = 0; i < NW; i++)
      chk(pcnt[i] == ((im1[i] == '1) ? 0 : 1), "R4/R7 pulses per word", pcnt[i],
          (im1[i] == '1) ? 0 : 1);
    chk(pcnt[1] == 0 && pcnt[4] == 0, "R7 all-ones skipped", pcnt[1] + pcnt[4], 0);
    chk(pulses_before_oe == nonff(im1), "R4 blind pass", pulses_before_oe, nonff(im1));
    chk(pulse_bad == 0, "R3 pulse width", pulse_bad, 0);
    chk(oe_bad == 0, "R8 verify read timing", oe_bad, 0);
    chk(up_gap == SW, "R2 raise order gap", up_gap, SW);
    chk(dn_gap == SW, "R2 lower order gap", dn_gap, SW);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    repeat (5) @(negedge clk);
    chk(!busy, "R1 no restart from busy start", busy, 0);
  endtask

  task automatic t_retry();
    bit ok;
    prep(im1);
    need[0] = 3; need[7] = MR + 1;
    kick(); wait_done(ok);
    chk(pass == 1, "R5 retries pass", pass, 1);
    chk(pcnt[0] == 3, "R5 word needing 3", pcnt[0], 3);
    chk(pcnt[7] == MR + 1, "R5 word needing max", pcnt[7], MR + 1);
    chk(pulse_bad == 0, "R3 retry pulse width", pulse_bad, 0);
  endtask

  task automatic t_exhaust();
    bit ok;
    prep(im1);
    need[5] = MR + 2;
    kick(); wait_done(ok);
    chk(pass == 0, "R6 fail pass flag", pass, 0);
    chk(fail_addr == 5, "R6 fail_addr", fail_addr, 5);
    chk(fail_retries == MR, "R6 fail_retries", fail_retries, MR);
    chk(pcnt[5] == MR + 1, "R6 pulses on failing word", pcnt[5], MR + 1);
    chk(pcnt[6] == 1, "R6 later word untouched", pcnt[6], 1);
    chk(!vcc_prog && !vpp_prog, "R6 supplies nominal at done",
        {vcc_prog, vpp_prog}, 0);
  endtask

  task automatic t_weak();
    bit ok;
    prep(im1);
    weak_addr = 3;
    kick(); wait_done(ok);
    chk(pass == 0, "R9 readback fail", pass, 0);
    chk(fail_addr == 3, "R9 readback fail_addr", fail_addr, 3);
    chk(fail_retries == 0, "R9 readback retries", fail_retries, 0);
    chk(pcnt[3] == 1, "R9 no extra pulses", pcnt[3], 1);
  endtask

  task automatic t_abort();
    bit ok;
    int n = 0;
    prep(im1);
    abort_test = 1;
    kick();
    while (pgm_n && n < 2000) begin @(negedge clk); n++; end
    chk(!pgm_n, "R10 reached pulse", pgm_n, 0);
    abort = 1;
    @(negedge clk) abort = 0;
    chk(pgm_n, "R10 strobe dropped", pgm_n, 1);
    wait_done(ok);
    chk(pass == 0, "R10 abort fails run", pass, 0);
    chk(!vcc_prog && !vpp_prog, "R10 supplies restored", {vcc_prog, vpp_prog}, 0);
    chk(dn_gap == SW, "R10/R2 lower order", dn_gap, SW);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_normal();
    t_retry();
    t_exhaust();
    t_weak();
    t_abort();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule